// File: doc/BRIEF.md
# Vector 128-bit Lane Shuffle Unit

This block assembles a destination vector out of whole 128-bit lanes taken from two source vectors. An 8-bit immediate chooses which lane of each source lands in each result lane. The immediate is read differently at the two supported vector lengths. At 512 bits, each of the four result lanes has a 2-bit selector. The low two result lanes draw from source A and the high two from source B. At 256 bits, each of the two result lanes has a 1-bit selector. Result lane 0 draws from source A and result lane 1 from source B.

After the lanes are shuffled, a per-element write mask is applied. An element-size input picks 32-bit elements, where all 16 mask bits are used, or 64-bit elements, where only the low 8 mask bits are used. A masked-off element either keeps the previous destination value (merging) or is cleared (zeroing). When masking is disabled, every element is written. A reserved vector-length code raises an illegal flag, and the previous destination passes through unchanged. The result is registered, so it appears one clock after the inputs are presented.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While reset is asserted, `dst_new` is all zeros and `illegal` is 0.
- R2: At 512-bit length (`vlen`=2'b10), result bits 127:0 equal source-A lane `imm[1:0]`, and result bits 255:128 equal source-A lane `imm[3:2]`. Lane k occupies bits 128k+127:128k.
- R3: At 512-bit length, result bits 383:256 equal source-B lane `imm[5:4]`, and result bits 511:384 equal source-B lane `imm[7:6]`.
- R4: At 256-bit length (`vlen`=2'b01), result bits 127:0 equal source-A lane `imm[0]`, and bits 255:128 equal source-B lane `imm[1]`. Bits `imm[7:2]` have no effect, and `illegal` stays 0.
- R5: At 256-bit length, result bits 511:256 are zero in every masking mode.
- R6: With `mask_en`=0, every live element takes the shuffled value, whatever `mask` holds.
- R7: With `elem64`=0, mask bit i governs bits 32i+31:32i for i in 0..15.
- R8: With `elem64`=1, mask bit i governs bits 64i+63:64i for i in 0..7, and `mask[15:8]` has no effect.
- R9: With `mask_en`=1 and `zero_mode`=0, an element whose mask bit is 0 takes the matching bits of `dst_old`.
- R10: With `mask_en`=1 and `zero_mode`=1, an element whose mask bit is 0 becomes zero.
- R11: For `vlen` codes 2'b00 and 2'b11, `illegal` is 1 and `dst_new` equals `dst_old`.
- R12: Every output reflects the inputs present at the previous rising clock edge. The outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| imm | input | 8 | Lane selection immediate |
| vlen | input | 2 | Length code: 01 = 256 bits, 10 = 512 bits, others reserved |
| elem64 | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| mask_en | input | 1 | Enables per-element masking |
| mask | input | 16 | Per-element write mask |
| zero_mode | input | 1 | 1 = zero masked-off elements, 0 = merge |
| dst_new | output | 512 | Registered destination result |
| illegal | output | 1 | Registered reserved-length flag |

## Verification
Every one of the 256 immediates is swept at both lengths. The sweep is run once with tagged sources, where each 32-bit word encodes its source and position, and once with random sources. A wrong selector bit, a swapped source or a wrong lane therefore shows up as a distinct value. Single-hot masks are walked across each element size in both merging and zeroing mode. This separates mask-to-element mapping faults from merge-versus-zero faults. Random upper mask bits in 64-bit mode, random masks with masking disabled, and the reserved length codes show whether the unused inputs leak into the result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    // vector-length selector codes
    typedef enum logic [1:0] {
        VL_RSV_LO = 2'b00,
        VL_256    = 2'b01,
        VL_512    = 2'b10,
        VL_RSV_HI = 2'b11
    } vlen_e;

    // narrowest element width supported; wider variants are powers of two above it
    localparam int BASE_ELEM_W   = 32;
    localparam int ELEM_VARIANTS = 2;

endpackage

// File: rtl/lsu_lane_pick.sv
module lsu_lane_pick #(
    parameter  int LANE_W = 128,
    parameter  int LANES  = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int IMM_W  = LANES * SEL_W
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             half,
    output logic [VEC_W-1:0] shuf
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // in full length the low half of the result comes from A, the high half from B
        localparam bit FULL_FROM_B = (j >= LANES / 2);
        // in half length only the low half of the lanes is live, split A then B
        localparam bit HALF_FROM_B = (j >= LANES / 4);
        localparam bit HALF_LIVE   = (j < LANES / 2);

        logic [SEL_W-1:0]  idx_full;
        logic [SEL_W-2:0]  idx_half;
        logic [LANE_W-1:0] from_full;
        logic [LANE_W-1:0] from_half;
        logic [LANE_W-1:0] lane_out;

        always_comb begin
            idx_full = imm[j*SEL_W +: SEL_W];
            idx_half = imm[j*(SEL_W-1) +: (SEL_W-1)];

            if (FULL_FROM_B) from_full = src_b[idx_full*LANE_W +: LANE_W];
            else             from_full = src_a[idx_full*LANE_W +: LANE_W];

            if (!HALF_LIVE)       from_half = '0;
            else if (HALF_FROM_B) from_half = src_b[idx_half*LANE_W +: LANE_W];
            else                  from_half = src_a[idx_half*LANE_W +: LANE_W];

            lane_out = half ? from_half : from_full;
        end

        assign shuf[j*LANE_W +: LANE_W] = lane_out;
    end

endmodule

// File: rtl/lsu_elem_mask.sv
module lsu_elem_mask #(
    parameter  int VEC_W = 512,
    parameter  int EW    = 32,
    localparam int NE    = VEC_W / EW
) (
    input  logic [VEC_W-1:0] shuf,
    input  logic [VEC_W-1:0] old,
    input  logic [NE-1:0]    mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             half,
    output logic [VEC_W-1:0] res
);

    for (genvar e = 0; e < NE; e++) begin : g_elem
        localparam bit LOW_HALF = (e < NE / 2);

        logic          live;
        logic          wr;
        logic [EW-1:0] val;

        always_comb begin
            live = LOW_HALF || !half;
            wr   = !mask_en || mask[e];
            if (!live)          val = '0;
            else if (wr)        val = shuf[e*EW +: EW];
            else if (zero_mode) val = '0;
            else                val = old[e*EW +: EW];
        end

        assign res[e*EW +: EW] = val;
    end

endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
    parameter  int LANE_W = 128,
    parameter  int LANES  = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int IMM_W  = LANES * SEL_W,
    localparam int MASK_W = VEC_W / lsu_pkg::BASE_ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  dst_old,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        vlen,
    input  logic              elem64,
    input  logic              mask_en,
    input  logic [MASK_W-1:0] mask,
    input  logic              zero_mode,
    output logic [VEC_W-1:0]  dst_new,
    output logic              illegal
);
    import lsu_pkg::*;

    typedef struct packed {
        logic [VEC_W-1:0] dst;
        logic             bad;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic             half;
    logic             vl_ok;
    logic [VEC_W-1:0] shuf;
    logic [VEC_W-1:0] masked [ELEM_VARIANTS];

    assign half  = (vlen == VL_256);
    assign vl_ok = (vlen == VL_256) || (vlen == VL_512);

    lsu_lane_pick #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_pick (
        .src_a (src_a),
        .src_b (src_b),
        .imm   (imm),
        .half  (half),
        .shuf  (shuf)
    );

    // one masking stage per element width; variant v handles BASE_ELEM_W << v
    for (genvar v = 0; v < ELEM_VARIANTS; v++) begin : g_var
        localparam int EW = BASE_ELEM_W << v;
        localparam int NE = VEC_W / EW;

        lsu_elem_mask #(
            .VEC_W (VEC_W),
            .EW    (EW)
        ) u_mask (
            .shuf      (shuf),
            .old       (dst_old),
            .mask      (mask[NE-1:0]),
            .mask_en   (mask_en),
            .zero_mode (zero_mode),
            .half      (half),
            .res       (masked[v])
        );
    end

    always_comb begin
        st_d = st_q;
        if (vl_ok) begin
            st_d.dst = elem64 ? masked[1] : masked[0];
            st_d.bad = 1'b0;
        end else begin
            st_d.dst = dst_old;
            st_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_new = st_q.dst;
    assign illegal = st_q.bad;

endmodule

// File: rtl/lane_shuffle_unit_chk.sv
module lane_shuffle_unit_chk #(
    parameter  int LANE_W = 128,
    parameter  int LANES  = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int IMM_W  = LANES * SEL_W,
    localparam int MASK_W = VEC_W / 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  src_b,
    input logic [VEC_W-1:0]  dst_old,
    input logic [IMM_W-1:0]  imm,
    input logic [1:0]        vlen,
    input logic              mask_en,
    input logic [MASK_W-1:0] mask,
    input logic              zero_mode,
    input logic [VEC_W-1:0]  dst_new,
    input logic              illegal
);

    logic              is256;
    logic              is512;
    logic [LANE_W-1:0] want0;
    logic [LANE_W-1:0] want1;
    logic [LANE_W-1:0] want2;
    logic [LANE_W-1:0] want3;

    assign is256 = (vlen == 2'b01);
    assign is512 = (vlen == 2'b10);

    always_comb begin
        want0 = src_a[imm[SEL_W-1:0]         * LANE_W +: LANE_W];
        want1 = src_a[imm[2*SEL_W-1:SEL_W]   * LANE_W +: LANE_W];
        want2 = src_b[imm[3*SEL_W-1:2*SEL_W] * LANE_W +: LANE_W];
        want3 = src_b[imm[IMM_W-1 -: SEL_W]  * LANE_W +: LANE_W];
    end

    a_r2_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (is512 && !mask_en) |=> dst_new[LANE_W-1:0] == $past(want0));

    a_r2_lane1: assert property (@(posedge clk) disable iff (!rst_n)
        (is512 && !mask_en) |=> dst_new[2*LANE_W-1:LANE_W] == $past(want1));

    a_r3_lane2: assert property (@(posedge clk) disable iff (!rst_n)
        (is512 && !mask_en) |=> dst_new[3*LANE_W-1:2*LANE_W] == $past(want2));

    a_r3_lane3: assert property (@(posedge clk) disable iff (!rst_n)
        (is512 && !mask_en) |=> dst_new[VEC_W-1 -: LANE_W] == $past(want3));

    a_r4_half_legal: assert property (@(posedge clk) disable iff (!rst_n)
        is256 |=> !illegal);

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is256 |=> dst_new[VEC_W-1:VEC_W/2] == '0);

    a_r9_merge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (is512 && mask_en && !zero_mode && mask == '0) |=> dst_new == $past(dst_old));

    a_r10_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
        ((is256 || is512) && mask_en && zero_mode && mask == '0) |=> dst_new == '0);

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!is256 && !is512) |=> (illegal && dst_new == $past(dst_old)));

endmodule

bind lane_shuffle_unit lane_shuffle_unit_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_old   (dst_old),
    .imm       (imm),
    .vlen      (vlen),
    .mask_en   (mask_en),
    .mask      (mask),
    .zero_mode (zero_mode),
    .dst_new   (dst_new),
    .illegal   (illegal)
);

// File: tb/lane_shuffle_unit_test.sv
`timescale 1ns/1ps
module lane_shuffle_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] dst_old = '0;
    logic [7:0]   imm = '0;
    logic [1:0]   vlen = 2'b10;
    logic         elem64 = 1'b0;
    logic         mask_en = 1'b0;
    logic [15:0]  mask = '0;
    logic         zero_mode = 1'b0;
    logic [511:0] dst_new;
    logic         illegal;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lane_shuffle_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .dst_old   (dst_old),
        .imm       (imm),
        .vlen      (vlen),
        .elem64    (elem64),
        .mask_en   (mask_en),
        .mask      (mask),
        .zero_mode (zero_mode),
        .dst_new   (dst_new),
        .illegal   (illegal)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    // behavioural model written from the requirements
    function automatic logic [511:0] model(
        input logic [511:0] a, input logic [511:0] b, input logic [511:0] old,
        input logic [7:0] im, input logic [1:0] vl, input logic e64,
        input logic men, input logic [15:0] m, input logic z);
        logic [511:0] sh;
        logic [511:0] out;
        int n_live;
        sh = '0;
        if (vl == 2'b10) begin
            for (int j = 0; j < 4; j++) begin
                int s;
                s = (im >> (2*j)) & 3;
                if (j < 2) sh[128*j +: 128] = a[128*s +: 128];
                else       sh[128*j +: 128] = b[128*s +: 128];
            end
        end else if (vl == 2'b01) begin
            sh[127:0]   = a[128*im[0] +: 128];
            sh[255:128] = b[128*im[1] +: 128];
        end else begin
            return old;
        end
        n_live = (e64 ? 8 : 16) / ((vl == 2'b01) ? 2 : 1);
        for (int c = 0; c < 16; c++) begin
            int e;
            e = e64 ? c / 2 : c;
            if (e >= n_live)          out[32*c +: 32] = '0;
            else if (!men || m[e])    out[32*c +: 32] = sh[32*c +: 32];
            else if (z)               out[32*c +: 32] = '0;
            else                      out[32*c +: 32] = old[32*c +: 32];
        end
        return out;
    endfunction

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [511:0] expect_now();
        return model(src_a, src_b, dst_old, imm, vlen, elem64, mask_en, mask, zero_mode);
    endfunction

    function automatic string mode_tag();
        if (vlen != 2'b01 && vlen != 2'b10) return "R11";
        if (!mask_en)  return "R6";
        if (zero_mode) return "R10";
        return "R9";
    endfunction

    initial begin
        logic [511:0] e;
        logic [511:0] prev;
        logic [511:0] tag_a;
        logic [511:0] tag_b;

        for (int i = 0; i < 16; i++) begin
            tag_a[32*i +: 32] = 32'hA000_0000 + i;
            tag_b[32*i +: 32] = 32'hB000_0000 + i;
        end

        // R1: reset state with busy inputs
        src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
        vlen = 2'b11; mask_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", dst_new, '0);
        chk1("R1", illegal, 1'b0);
        rst_n = 1'b1;

        // R2/R3: every immediate at 512, tagged then random sources
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 256; k++) begin
                src_a = pass == 0 ? tag_a : rnd512();
                src_b = pass == 0 ? tag_b : rnd512();
                dst_old = rnd512();
                imm = 8'(k); vlen = 2'b10; elem64 = k[0]; mask_en = 1'b0;
                mask = 16'($urandom);
                e = expect_now();
                step();
                chk("R2", {256'b0, dst_new[255:0]}, {256'b0, e[255:0]});
                chk("R3", {256'b0, dst_new[511:256]}, {256'b0, e[511:256]});
            end
        end

        // R4/R5: every immediate at 256
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 256; k++) begin
                src_a = pass == 0 ? tag_a : rnd512();
                src_b = pass == 0 ? tag_b : rnd512();
                dst_old = rnd512();
                imm = 8'(k); vlen = 2'b01; elem64 = k[1]; mask_en = 1'b0;
                e = '0;
                e[127:0]   = src_a[128*k[0] +: 128];
                e[255:128] = src_b[128*k[1] +: 128];
                step();
                chk("R4", {256'b0, dst_new[255:0]}, e);
                chk("R5", {256'b0, dst_new[511:256]}, '0);
                chk1("R4", illegal, 1'b0);
            end
        end

        // R7: single-hot masks, 32-bit elements, both modes
        for (int z = 0; z < 2; z++) begin
            for (int k = 0; k < 16; k++) begin
                src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
                imm = 8'($urandom); vlen = 2'b10; elem64 = 1'b0;
                mask_en = 1'b1; mask = 16'(1) << k; zero_mode = z[0];
                e = expect_now();
                step();
                chk("R7", dst_new, e);
            end
        end

        // R8: single-hot masks, 64-bit elements, random upper mask bits
        for (int z = 0; z < 2; z++) begin
            for (int k = 0; k < 8; k++) begin
                src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
                imm = 8'($urandom); vlen = 2'b10; elem64 = 1'b1;
                mask_en = 1'b1; zero_mode = z[0];
                mask = {8'($urandom) | 8'h01, 8'(1) << k};
                e = model(src_a, src_b, dst_old, imm, vlen, 1'b1, 1'b1, {8'h00, mask[7:0]}, zero_mode);
                step();
                chk("R8", dst_new, e);
            end
        end

        // R9/R10/R5: random masks in both modes, both lengths, both sizes
        for (int k = 0; k < 128; k++) begin
            src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
            imm = 8'($urandom); vlen = k[0] ? 2'b01 : 2'b10; elem64 = k[1];
            mask_en = 1'b1; mask = 16'($urandom); zero_mode = k[2];
            e = expect_now();
            step();
            chk(zero_mode ? "R10" : "R9", dst_new, e);
            if (vlen == 2'b01) chk("R5", {256'b0, dst_new[511:256]}, '0);
        end

        // R6: masking disabled, mask contents irrelevant
        for (int k = 0; k < 32; k++) begin
            src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
            imm = 8'($urandom); vlen = k[0] ? 2'b01 : 2'b10; elem64 = k[1];
            mask_en = 1'b0; mask = 16'($urandom); zero_mode = k[2];
            e = model(src_a, src_b, dst_old, imm, vlen, elem64, 1'b0, 16'hFFFF, 1'b0);
            step();
            chk("R6", dst_new, e);
        end

        // R11: reserved length codes pass the old destination
        for (int k = 0; k < 16; k++) begin
            src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
            imm = 8'($urandom); vlen = k[0] ? 2'b11 : 2'b00; elem64 = k[1];
            mask_en = k[2]; mask = 16'($urandom); zero_mode = k[3];
            step();
            chk("R11", dst_new, dst_old);
            chk1("R11", illegal, 1'b1);
        end

        // R12: outputs hold until the next edge, then follow the inputs
        for (int k = 0; k < 8; k++) begin
            prev = dst_new;
            src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
            imm = 8'($urandom); vlen = 2'b10; elem64 = k[0];
            mask_en = k[1]; mask = 16'($urandom); zero_mode = k[2];
            e = expect_now();
            #1;
            chk("R12", dst_new, prev);
            step();
            chk("R12", dst_new, e);
        end

        // random mix of all modes including reserved codes
        for (int k = 0; k < 400; k++) begin
            src_a = rnd512(); src_b = rnd512(); dst_old = rnd512();
            imm = 8'($urandom); vlen = 2'($urandom); elem64 = 1'($urandom);
            mask_en = 1'($urandom); mask = 16'($urandom); zero_mode = 1'($urandom);
            e = expect_now();
            step();
            chk(mode_tag(), dst_new, e);
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule